// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the port-to-port interrupt flags that sit beside a shared memory with two independent access ports, a left port and a right port. It watches each port's enable, write strobe, output enable, address and busy input, and reserves the two top locations of the address space as mailboxes. The very top location (all address bits one) belongs to the right port. The location one below it belongs to the left port. The data in those locations is kept by the memory array itself. This block only tracks whether a message is waiting.

A port posts a message by writing into the other port's mailbox, which raises the other port's interrupt. The receiving port drops its own interrupt by reading its own mailbox. A busy indication to a port stops that port both from raising the peer's interrupt and from clearing its own. Both flags are active low. They are registered, so they change on the clock edge that samples the access. The address width is a parameter, so one netlist serves any memory depth.

Top module: `mbox_irq`

## Requirements
- R1: A synchronous reset drives both `l_irq_n` and `r_irq_n` high (no message waiting) on the edge at which `rst` is sampled high, at any time.
- R2: A left write (`l_en`=1, `l_wr`=1) to the all-ones address with `l_busy`=0 drives `r_irq_n` low after that clock edge.
- R3: A right write (`r_en`=1, `r_wr`=1) to the all-ones-minus-one address with `r_busy`=0 drives `l_irq_n` low after that clock edge.
- R4: A right read of the all-ones address with `r_busy`=0 returns `r_irq_n` high. A left read of the all-ones-minus-one address with `l_busy`=0 returns `l_irq_n` high. Each takes effect after the sampling edge.
- R5: A port reading the other port's mailbox leaves both flags unchanged.
- R6: While a port's busy input is 1, its write into the peer's mailbox leaves the peer's flag unchanged.
- R7: While a port's busy input is 1, its read of its own mailbox leaves its own flag unchanged.
- R8: A read needs enable=1, output enable=1 and write strobe=0. A write needs enable=1 and write strobe=1. With enable=0, no strobe has any effect. With output enable=0 and write strobe=0, there is no access.
- R9: If a set and a clear of the same flag fall in the same cycle, the flag ends set (low).
- R10: Accesses to any address other than the two mailboxes leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left port write strobe, active high |
| l_oe | input | 1 | Left port output enable, active high |
| l_busy | input | 1 | Busy to left port, active high |
| l_addr | input | AW | Left port address |
| r_en | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right port write strobe, active high |
| r_oe | input | 1 | Right port output enable, active high |
| r_busy | input | 1 | Busy to right port, active high |
| r_addr | input | AW | Right port address |
| l_irq_n | output | 1 | Left interrupt, low when a message is waiting |
| r_irq_n | output | 1 | Right interrupt, low when a message is waiting |

## Verification
Posting a message and retiring one can land on the same flag in the same cycle. This happens when one port writes into a mailbox while the owner reads that same mailbox. The bench provokes it in both directions with both ports active on a single edge. It expects the flag to end low, because setting takes priority. A further vector has both ports retire their own messages at once, to show that the two flags act independently.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  typedef struct packed {
    logic en;
    logic wr;
    logic oe;
    logic busy;
  } port_ctl_t;

  function automatic logic ctl_is_write(port_ctl_t c);
    return c.en && c.wr;
  endfunction

  function automatic logic ctl_is_read(port_ctl_t c);
    return c.en && c.oe && !c.wr;
  endfunction

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter int AW = 14,
  parameter logic [AW-1:0] OWN_BOX  = '1,
  parameter logic [AW-1:0] PEER_BOX = '1
) (
  input  port_ctl_t       ctl,
  input  logic [AW-1:0]   addr,
  output logic            post_peer,
  output logic            take_own
);

  logic hit_own, hit_peer;

  always_comb begin
    hit_own   = (addr == OWN_BOX);
    hit_peer  = (addr == PEER_BOX);
    post_peer = ctl_is_write(ctl) && hit_peer && !ctl.busy;
    take_own  = ctl_is_read(ctl)  && hit_own  && !ctl.busy;
  end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_n
);

  always_ff @(posedge clk) begin
    if (rst)        flag_n <= 1'b1;
    else if (set_i) flag_n <= 1'b0;
    else if (clr_i) flag_n <= 1'b1;
  end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic          l_busy,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic          r_busy,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);

  localparam int NSIDE = 2;
  localparam logic [AW-1:0] BOX_R = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_L = BOX_R - 1'b1;

  port_ctl_t       ctl  [NSIDE];
  logic [AW-1:0]   addr [NSIDE];
  logic            post [NSIDE];
  logic            take [NSIDE];
  logic            irq_n[NSIDE];

  assign ctl[SIDE_L]  = '{en: l_en, wr: l_wr, oe: l_oe, busy: l_busy};
  assign ctl[SIDE_R]  = '{en: r_en, wr: r_wr, oe: r_oe, busy: r_busy};
  assign addr[SIDE_L] = l_addr;
  assign addr[SIDE_R] = r_addr;

  for (genvar p = 0; p < NSIDE; p++) begin : g_side
    localparam logic [AW-1:0] OWN  = (p == int'(SIDE_R)) ? BOX_R : BOX_L;
    localparam logic [AW-1:0] PEER = (p == int'(SIDE_R)) ? BOX_L : BOX_R;

    mbox_port_dec #(.AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .ctl       (ctl[p]),
      .addr      (addr[p]),
      .post_peer (post[p]),
      .take_own  (take[p])
    );

    // a flag is raised by the opposite side and retired by its owner
    mbox_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (post[NSIDE-1-p]),
      .clr_i  (take[p]),
      .flag_n (irq_n[p])
    );
  end

  assign l_irq_n = irq_n[SIDE_L];
  assign r_irq_n = irq_n[SIDE_R];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          l_en,
  input logic          l_wr,
  input logic          l_oe,
  input logic          l_busy,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic          r_wr,
  input logic          r_oe,
  input logic          r_busy,
  input logic [AW-1:0] r_addr,
  input logic          l_irq_n,
  input logic          r_irq_n
);

  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

  logic l_post, r_post, l_take, r_take;
  assign l_post = l_en && l_wr && !l_busy && (l_addr == TOP);
  assign r_post = r_en && r_wr && !r_busy && (r_addr == TOP1);
  assign l_take = l_en && l_oe && !l_wr && !l_busy && (l_addr == TOP1);
  assign r_take = r_en && r_oe && !r_wr && !r_busy && (r_addr == TOP);

  assert_reset_high_R1: assert property (@(posedge clk)
    rst |=> (l_irq_n && r_irq_n));

  assert_left_post_R2: assert property (@(posedge clk) disable iff (rst)
    l_post |=> !r_irq_n);

  assert_right_post_R3: assert property (@(posedge clk) disable iff (rst)
    r_post |=> !l_irq_n);

  assert_right_take_R4: assert property (@(posedge clk) disable iff (rst)
    (r_take && !l_post) |=> r_irq_n);

  assert_left_take_R4: assert property (@(posedge clk) disable iff (rst)
    (l_take && !r_post) |=> l_irq_n);

  // R5, R6, R7, R8 and R10: with no qualified access, a flag holds
  assert_left_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!r_post && !l_take) |=> $stable(l_irq_n));

  assert_right_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!l_post && !r_take) |=> $stable(r_irq_n));

endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbox_irq_test.sv
module mbox_irq_test;

  localparam int AW = 14;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] TOP1 = TOP - 1'b1;
  localparam logic [AW-1:0] OTH  = 14'h0005;

  typedef struct packed {
    logic le, lw, lo, lb;
    logic [AW-1:0] la;
    logic re, rw, ro, rb;
    logic [AW-1:0] ra;
    logic el, er;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TAB [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b1}, // 0 idle R10
    '{1'b1,1'b1,1'b0,1'b0, TOP,  1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b0}, // 1 R2
    '{1'b1,1'b0,1'b1,1'b0, TOP,  1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b0}, // 2 R5
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b0,1'b1,1'b1, TOP,  1'b1,1'b0}, // 3 R7
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b0,1'b0,1'b0, TOP,  1'b1,1'b0}, // 4 R8
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b0,1'b1,1'b0, TOP,  1'b1,1'b1}, // 5 R4
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b1,1'b0,1'b1, TOP1, 1'b1,1'b1}, // 6 R6
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b1,1'b0,1'b0, TOP1, 1'b0,1'b1}, // 7 R3
    '{1'b0,1'b0,1'b1,1'b0, TOP1, 1'b0,1'b0,1'b0,1'b0, OTH,  1'b0,1'b1}, // 8 R8
    '{1'b1,1'b1,1'b0,1'b0, OTH,  1'b1,1'b0,1'b1,1'b0, OTH,  1'b0,1'b1}, // 9 R10
    '{1'b1,1'b0,1'b1,1'b0, TOP1, 1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b1}, // 10 R4
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b0,1'b1,1'b0,1'b0, TOP1, 1'b1,1'b1}, // 11 R8
    '{1'b1,1'b0,1'b1,1'b0, TOP1, 1'b1,1'b1,1'b0,1'b0, TOP1, 1'b0,1'b1}, // 12 R9
    '{1'b1,1'b1,1'b0,1'b0, TOP,  1'b1,1'b0,1'b1,1'b0, TOP,  1'b0,1'b0}, // 13 R9
    '{1'b0,1'b0,1'b0,1'b0, OTH,  1'b1,1'b0,1'b1,1'b0, TOP1, 1'b0,1'b0}, // 14 R5
    '{1'b1,1'b0,1'b1,1'b0, TOP1, 1'b1,1'b0,1'b1,1'b0, TOP,  1'b1,1'b1}  // 15 R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_en = 0, l_wr = 0, l_oe = 0, l_busy = 0;
  logic r_en = 0, r_wr = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  mbox_irq #(.AW(AW)) uut (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic check(input string req, input logic el, input logic er);
    n_run++;
    if (l_irq_n !== el || r_irq_n !== er) begin
      n_fail++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b", req, l_irq_n, r_irq_n, el, er);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    {l_en, l_wr, l_oe, l_busy, l_addr} = {v.le, v.lw, v.lo, v.lb, v.la};
    {r_en, r_wr, r_oe, r_busy, r_addr} = {v.re, v.rw, v.ro, v.rb, v.ra};
    @(negedge clk);
    {l_en, l_wr, l_oe, l_busy, r_en, r_wr, r_oe, r_busy} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b1, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(TAB[i]);
      check($sformatf("vector %0d", i), TAB[i].el, TAB[i].er);
    end
    // R9 / R2: post to right, then set both; then reset mid-run clears both (R1)
    drive('{1'b1,1'b1,1'b0,1'b0, TOP, 1'b1,1'b1,1'b0,1'b0, TOP1, 1'b0,1'b0});
    check("R2 R3 both posted", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset mid-run", 1'b1, 1'b1);
    // R1: reset wins over a simultaneous post
    @(negedge clk); rst = 1'b1; l_en = 1; l_wr = 1; l_addr = TOP;
    @(negedge clk); rst = 1'b0; l_en = 0; l_wr = 0;
    check("R1 reset over post", 1'b1, 1'b1);
    // R6 left busy blocks post to right
    drive('{1'b1,1'b1,1'b0,1'b1, TOP, 1'b0,1'b0,1'b0,1'b0, OTH, 1'b1,1'b1});
    check("R6 left busy", 1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: done=%b expected 1", done);
    end
  end

  initial begin
    wait (done || n_fail > 0 && 0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5001) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule